// File: doc/BRIEF.md
# Decrementing Error Threshold Counter

This block is a bank of per-channel error counters for a memory controller. Each channel keeps a control word that software can read and write over a simple single-cycle register bus. The word holds a count, an arm flag and an interrupt enable. Each channel's control word sits on its own 4 KiB page. The error-detection logic reports one flag per channel for each 16-byte data chunk found to be in error. While a channel is armed, every reported chunk lowers that channel's count by one.

Software loads a count and sets the arm flag. When the count steps from one to zero, the hardware clears the arm flag. If the enable bit was also set at that moment, the channel sends a one-cycle pulse to the interrupt controller. A write from software always wins over an error report that arrives in the same cycle. Reads are registered and return the word as it was before the clock edge.

Top module: `errcnt_bank`

## Requirements
- R1: After reset, every channel reads back as zero and no interrupt line is high.
- R2: The word layout is as follows: bits 15:0 hold the count, bit 16 the arm flag and bit 17 the interrupt enable. A write stores all three fields. A read issued in one cycle shows its data on `bus_rdata` in the next cycle. `bus_rdata` is zero in any cycle that follows no valid read.
- R3: Bits 63:18 always read as zero, and writing ones to them has no effect.
- R4: Channel n (n = 0..3) responds only at byte offset n*4096. Writes to any other offset change no channel, and reads from any other offset return zero.
- R5: While the arm flag is 1 and the count is nonzero, each cycle with that channel's error input high lowers the count by exactly one.
- R6: While the arm flag is 0, the error input leaves the count unchanged and raises no interrupt.
- R7: The decrement from 1 to 0 clears the arm flag at the same clock edge and leaves the enable bit unchanged.
- R8: The interrupt line of a channel goes high for exactly one cycle, in the cycle where the arm flag first reads cleared after a 1-to-0 decrement. It does so only if the enable bit was 1.
- R9: When a write to a channel and an error for that channel arrive in the same cycle, the written value is stored and the error is dropped.
- R10: Writing count 0 with the arm flag set raises no interrupt. An error arriving while the count is already 0 neither wraps the count nor raises an interrupt.
- R11: An error on one channel never changes another channel's word or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset from the bank base |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after a read |
| chunk_err | input | 4 | One flag per channel: an erroneous 16-byte chunk this cycle |
| irq | output | 4 | One-cycle interrupt pulse per channel |

## Verification
The hardest situation to reach from the ports is a write and an error landing on the same channel at the same clock edge. A directed task raises the error flag and a write request on the same falling edge, then reads the word back to show that the written value is the one kept. The 1-to-0 transition is reached by loading small counts and applying spaced error pulses. The interrupt line is sampled in the cycle after each pulse and again one cycle later, which shows both when the pulse appears and that it lasts a single cycle.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

    parameter int CNT_W       = 16;
    parameter int DATA_W      = 64;
    parameter int NUM_CH      = 4;
    parameter int ADDR_W      = 16;
    parameter int STRIDE_LOG2 = 12;

    localparam int USED_W = CNT_W + 2;

    // Packed MSB first: enable at bit CNT_W+1, arm flag at CNT_W, count below.
    typedef struct packed {
        logic             enb;
        logic             valid;
        logic [CNT_W-1:0] count;
    } ctrl_word_t;

    function automatic logic [DATA_W-1:0] pack_word(input ctrl_word_t w);
        return {{(DATA_W-USED_W){1'b0}}, w};
    endfunction

    function automatic ctrl_word_t unpack_word(input logic [DATA_W-1:0] d);
        return ctrl_word_t'(d[USED_W-1:0]);
    endfunction

endpackage

// File: rtl/errcnt_decode.sv
module errcnt_decode #(
    parameter int ADDR_W      = 16,
    parameter int NUM_CH      = 4,
    parameter int STRIDE_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [NUM_CH-1:0] page_sel
);
    logic [ADDR_W-1:0] page;
    logic              aligned;

    assign page    = addr >> STRIDE_LOG2;
    assign aligned = (addr[STRIDE_LOG2-1:0] == '0);
    assign hit     = aligned && (page < ADDR_W'(NUM_CH));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign page_sel[g] = hit && (page == ADDR_W'(g));
    end
endmodule

// File: rtl/errcnt_channel.sv
module errcnt_channel
    import errcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_word_t wr_word,
    input  logic       chunk_err,
    output ctrl_word_t word,
    output logic       irq
);
    ctrl_word_t word_q;
    logic       irq_q;
    logic       step;
    logic       last_step;

    assign step      = word_q.valid && chunk_err && (word_q.count != '0);
    assign last_step = step && (word_q.count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_en) begin
                word_q <= wr_word;
            end else if (step) begin
                word_q.count <= word_q.count - CNT_W'(1);
                if (last_step) begin
                    word_q.valid <= 1'b0;
                    irq_q        <= word_q.enb;
                end
            end
        end
    end

    assign word = word_q;
    assign irq  = irq_q;
endmodule

// File: rtl/errcnt_bank.sv
module errcnt_bank
    import errcnt_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int A_W    = ADDR_W,
    parameter int STRIDE = STRIDE_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [A_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   chunk_err,
    output logic [N_CH-1:0]   irq
);
    logic                       hit;
    logic [N_CH-1:0]            page_sel;
    logic [N_CH-1:0]            wr_sel;
    ctrl_word_t                 wr_word;
    ctrl_word_t                 words [N_CH];
    ctrl_word_t                 rd_word;
    logic [DATA_W-1:0]          rdata_q;
    logic [N_CH-1:0][CNT_W-1:0] ch_count;
    logic [N_CH-1:0]            ch_valid;
    logic [N_CH-1:0]            ch_enb;

    errcnt_decode #(.ADDR_W(A_W), .NUM_CH(N_CH), .STRIDE_LOG2(STRIDE)) u_dec (
        .addr     (bus_addr),
        .hit      (hit),
        .page_sel (page_sel)
    );

    assign wr_sel  = page_sel & {N_CH{bus_sel && bus_we}};
    assign wr_word = unpack_word(bus_wdata);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        errcnt_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_sel[g]),
            .wr_word   (wr_word),
            .chunk_err (chunk_err[g]),
            .word      (words[g]),
            .irq       (irq[g])
        );
        assign ch_count[g] = words[g].count;
        assign ch_valid[g] = words[g].valid;
        assign ch_enb[g]   = words[g].enb;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (page_sel[i]) rd_word = rd_word | words[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= (bus_sel && !bus_we && hit) ? pack_word(rd_word) : '0;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/errcnt_checker.sv
module errcnt_checker
    import errcnt_pkg::*;
#(
    parameter int N_CH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [N_CH-1:0]            irq,
    input logic [N_CH-1:0]            chunk_err,
    input logic [N_CH-1:0]            wr_sel,
    input logic [CNT_W-1:0]           wr_count,
    input logic [DATA_W-1:0]          rdata,
    input logic [N_CH-1:0][CNT_W-1:0] ch_count,
    input logic [N_CH-1:0]            ch_valid,
    input logic [N_CH-1:0]            ch_enb
);
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:USED_W] == '0);

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
            irq[g] |=> !irq[g]);

        p_irq_disarmed_r7: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> (!ch_valid[g] && ch_count[g] == '0 && ch_enb[g]));

        p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[g]) |-> ($past(ch_valid[g]) && $past(ch_enb[g]) &&
                               $past(chunk_err[g]) && !$past(wr_sel[g]) &&
                               $past(ch_count[g]) == CNT_W'(1)));

        p_step_r5: assert property (@(posedge clk) disable iff (rst)
            (ch_valid[g] && chunk_err[g] && !wr_sel[g] && ch_count[g] != '0)
            |=> ch_count[g] == $past(ch_count[g]) - CNT_W'(1));

        p_idle_r6: assert property (@(posedge clk) disable iff (rst)
            (!ch_valid[g] && !wr_sel[g]) |=> ($stable(ch_count[g]) && !irq[g]));

        p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
            wr_sel[g] |=> (ch_count[g] == $past(wr_count) && !irq[g]));
    end
endmodule

bind errcnt_bank errcnt_checker #(.N_CH(N_CH)) u_errcnt_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .chunk_err (chunk_err),
    .wr_sel    (wr_sel),
    .wr_count  (bus_wdata[errcnt_pkg::CNT_W-1:0]),
    .rdata     (bus_rdata),
    .ch_count  (ch_count),
    .ch_valid  (ch_valid),
    .ch_enb    (ch_enb)
);

// File: tb/errcnt_bank_test.sv
module errcnt_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [3:0]  chunk_err = '0;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    errcnt_bank uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chunk_err(chunk_err), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ch_addr(input int ch);
        return 16'(ch * 4096);
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // Spaced error pulses; counts interrupt pulses and any pulse longer than one cycle.
    task automatic apply_err(input int ch, input int n, output int pulses,
                             output int long_pulses, output int stray);
        pulses = 0; long_pulses = 0; stray = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chunk_err[ch] = 1'b1;
            @(negedge clk);
            chunk_err[ch] = 1'b0;
            if (irq[ch]) pulses++;
            if ((irq & ~(4'b1 << ch)) != 0) stray++;
            @(negedge clk);
            if (irq[ch]) long_pulses++;
        end
    endtask

    task automatic t_reset;
        logic [63:0] d;
        for (int c = 0; c < 4; c++) begin
            bus_read(ch_addr(c), d);
            check("R1 reset word", d, 64'h0);
        end
        check("R1 reset irq", 64'(irq), 64'h0);
        check("R2 idle rdata", bus_rdata, 64'h0);
    endtask

    task automatic t_layout;
        logic [63:0] d;
        bus_write(ch_addr(0), 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(ch_addr(0), d);
        check("R3 upper bits zero", d, 64'h3_FFFF);
        bus_write(ch_addr(0), 64'h0000_0000_0002_1234);
        bus_read(ch_addr(0), d);
        check("R2 field layout", d, 64'h2_1234);
    endtask

    task automatic t_decode;
        logic [63:0] d;
        bus_write(ch_addr(3), 64'h1_0042);
        bus_write(16'h3004, 64'h0_0099);
        bus_write(16'h4000, 64'h0_0077);
        bus_read(ch_addr(3), d);
        check("R4 ch3 at 0x3000, stray writes ignored", d, 64'h1_0042);
        bus_read(16'h3004, d);
        check("R4 unaligned read zero", d, 64'h0);
        bus_read(16'h4000, d);
        check("R4 out of range read zero", d, 64'h0);
        bus_read(ch_addr(0), d);
        check("R4 ch0 untouched", d, 64'h2_1234);
    endtask

    task automatic t_decrement;
        logic [63:0] d;
        int p, lp, s;
        bus_write(ch_addr(1), 64'h1_0005);
        apply_err(1, 3, p, lp, s);
        bus_read(ch_addr(1), d);
        check("R5 count lowered by three", d, 64'h1_0002);
        check("R5 no irq", 64'(p), 64'h0);
    endtask

    task automatic t_disarmed;
        logic [63:0] d;
        int p, lp, s;
        bus_write(ch_addr(2), 64'h2_0007);
        apply_err(2, 3, p, lp, s);
        bus_read(ch_addr(2), d);
        check("R6 disarmed count held", d, 64'h2_0007);
        check("R6 disarmed no irq", 64'(p), 64'h0);
    endtask

    task automatic t_reach_zero;
        logic [63:0] d;
        int p, lp, s;
        bus_write(ch_addr(1), 64'h3_0002);
        apply_err(1, 2, p, lp, s);
        check("R8 one irq pulse", 64'(p), 64'h1);
        check("R8 pulse one cycle", 64'(lp), 64'h0);
        check("R11 other irq lines quiet", 64'(s), 64'h0);
        bus_read(ch_addr(1), d);
        check("R7 arm cleared enable kept", d, 64'h2_0000);
        apply_err(1, 2, p, lp, s);
        bus_read(ch_addr(1), d);
        check("R6 after disarm held", d, 64'h2_0000);
        check("R6 after disarm no irq", 64'(p), 64'h0);
    endtask

    task automatic t_no_enable;
        logic [63:0] d;
        int p, lp, s;
        bus_write(ch_addr(3), 64'h1_0001);
        apply_err(3, 1, p, lp, s);
        check("R8 enable off no irq", 64'(p), 64'h0);
        bus_read(ch_addr(3), d);
        check("R7 arm cleared without enable", d, 64'h0);
    endtask

    task automatic t_collision;
        logic [63:0] d;
        bus_write(ch_addr(0), 64'h3_0009);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ch_addr(0);
        bus_wdata = 64'h3_0001; chunk_err[0] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; chunk_err[0] = 1'b0;
        check("R9 no irq on collision", 64'(irq[0]), 64'h0);
        bus_read(ch_addr(0), d);
        check("R9 write wins", d, 64'h3_0001);
    endtask

    task automatic t_zero_write;
        logic [63:0] d;
        int p, lp, s;
        bus_write(ch_addr(0), 64'h3_0000);
        check("R10 zero write no irq", 64'(irq[0]), 64'h0);
        @(negedge clk);
        check("R10 zero write no irq later", 64'(irq[0]), 64'h0);
        apply_err(0, 2, p, lp, s);
        check("R10 no irq at zero", 64'(p), 64'h0);
        bus_read(ch_addr(0), d);
        check("R10 count does not wrap", d, 64'h3_0000);
    endtask

    task automatic t_independent;
        logic [63:0] d;
        int p, lp, s;
        bus_write(ch_addr(1), 64'h1_0003);
        bus_write(ch_addr(2), 64'h3_0003);
        apply_err(1, 2, p, lp, s);
        bus_read(ch_addr(2), d);
        check("R11 neighbour untouched", d, 64'h3_0003);
        bus_read(ch_addr(1), d);
        check("R11 own channel lowered", d, 64'h1_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_layout();
        t_decode();
        t_decrement();
        t_disarmed();
        t_reach_zero();
        t_no_enable();
        t_collision();
        t_zero_write();
        t_independent();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule